// File: doc/BRIEF.md
# Register-Programmed Two-Wire Command Master

This block lets a host run single byte or word transfers to management devices on a memory module (serial presence EEPROMs, temperature sensors) over an open-drain two-wire bus. The host sets a control word that holds the upper part of the target address and the guard bits. It then writes a command word whose top bit fires the transfer. The block sequences start, address, command byte, an optional repeated start with a read address, one or two data bytes and stop. Progress, completion and the returned data are read back from a status word.

The target address is split across both registers. Completion flags are kept per direction, so a read never disturbs the write flag and a write never disturbs the read flag. Word data is held with the first bus byte in the low half of the field. Software swaps the halves to get a big-endian sensor value.

Top module: `smb_cmd_master`

## Requirements
- R1: After reset the control, command and status words read 0 and both bus lines are released (scl_oe_o = sda_oe_o = 0).
- R2: A write to the command word (address 1) with bit 31 set starts a transfer. Status bit 31 (busy) reads 1 from the cycle after that write until the stop condition has been driven. A trigger written while busy is ignored.
- R3: A trigger is ignored (no bus activity, status unchanged) while control bit 27 (clock enable) is 0.
- R4: The 7-bit target address is control bits 31:28 followed by command bits 26:24, and it is sent with R/W as bit 0 (0 write, 1 read). A read sends address+W, the command byte (bits 23:16), a repeated start, then address+R.
- R5: Command bit 27 selects a write and bit 29 a word. A byte write sends only data bits 7:0, and bits 15:8 have no effect. A word write sends bits 7:0 and then bits 15:8.
- R6: A byte read returns its byte in status bits 7:0 with bits 15:8 at 0. A word read returns the first bus byte in bits 7:0 and the second in bits 15:8. The master ACKs every read byte except the last, which it NACKs.
- R7: Status bit 30 (read done) is cleared only when a read starts and set when it ends. Status bit 29 (write done) is cleared only when a write starts and set when it ends. A transfer in one direction leaves the other flag unchanged.
- R8: A NACK from the target sets status bit 28 (bus error) and the transfer ends with a stop and the direction's done flag set. The error bit is cleared when the next transfer is accepted.
- R9: While control bit 26 (write lock) is 1, a write trigger is ignored: no bus activity and the status is unchanged. Reads still run.
- R10: Control bit 9 (sensor poll enable) and bits 31:28, 27 and 26 read back as written. Bit 9 has no effect on transfers.
- R11: The bus lines are released whenever the block is idle. Within a byte, the master changes its SDA drive only while SCL is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word select: 0 control, 1 command, 2 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| sda_i | input | 1 | Sampled level of the SDA line |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |

## Verification
A bench target model logs every byte it receives and every acknowledge the master gives. A scoreboard compares these against the bytes predicted from each command word. All four combinations of byte or word and read or write are run. A byte write with a non-zero upper data byte shows that bits 15:8 are dropped, and the two-byte reads show byte placement and the final NACK. An absent address separates the error path from a normal completion. Alternating read and write runs show that each done flag survives the other direction. Retriggers while busy, with the write lock set and with the clock enable cleared must produce no bus bytes and no status change.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CMD  = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  // command word fields
  localparam int CMD_TRIG     = 31;
  localparam int CMD_WORD     = 29;
  localparam int CMD_WRITE    = 27;
  localparam int CMD_ADDR_LSB = 24;
  localparam int CMD_CODE_LSB = 16;
  // control word fields
  localparam int CTRL_TYPE_LSB = 28;
  localparam int CTRL_CLKEN    = 27;
  localparam int CTRL_WLOCK    = 26;
  localparam int CTRL_POLL     = 9;
  // status word fields
  localparam int STAT_BUSY  = 31;
  localparam int STAT_RDONE = 30;
  localparam int STAT_WDONE = 29;
  localparam int STAT_ERR   = 28;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDR_W, ST_CMD, ST_WDATA,
    ST_RSTART, ST_ADDR_R, ST_RDATA, ST_STOP
  } xfer_state_e;

  typedef struct packed {
    logic [6:0]  addr;
    logic [7:0]  code;
    logic [15:0] wdata;
    logic        word;
    logic        write;
  } xfer_req_t;
endpackage

// File: rtl/smb_tick_gen.sv
module smb_tick_gen #(
  parameter int unsigned QTR_CYC = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);
endmodule

// File: rtl/smb_csr.sv
module smb_csr
  import smb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [1:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        busy_i,
  input  logic        done_i,
  input  logic        err_i,
  input  logic [15:0] xfer_rdata_i,
  output logic        start_o,
  output xfer_req_t   req_o
);
  logic [3:0]  type_q;
  logic        clken_q, wlock_q, poll_q;
  logic [31:0] cmd_q;
  logic        rdone_q, wdone_q, err_q, dir_wr_q;
  logic [15:0] data_q;
  logic        trig_wr;

  assign trig_wr = we_i && (addr_i == REG_CMD) && wdata_i[CMD_TRIG];
  // qualify trigger: idle, clock enabled, writes not locked
  assign start_o = trig_wr && !busy_i && clken_q && !(wdata_i[CMD_WRITE] && wlock_q);

  assign req_o.addr  = {type_q, wdata_i[CMD_ADDR_LSB +: 3]};
  assign req_o.code  = wdata_i[CMD_CODE_LSB +: 8];
  assign req_o.wdata = wdata_i[15:0];
  assign req_o.word  = wdata_i[CMD_WORD];
  assign req_o.write = wdata_i[CMD_WRITE];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q   <= '0;
      clken_q  <= 1'b0;
      wlock_q  <= 1'b0;
      poll_q   <= 1'b0;
      cmd_q    <= '0;
      rdone_q  <= 1'b0;
      wdone_q  <= 1'b0;
      err_q    <= 1'b0;
      dir_wr_q <= 1'b0;
      data_q   <= '0;
    end else begin
      if (we_i && addr_i == REG_CTRL) begin
        type_q  <= wdata_i[CTRL_TYPE_LSB +: 4];
        clken_q <= wdata_i[CTRL_CLKEN];
        wlock_q <= wdata_i[CTRL_WLOCK];
        poll_q  <= wdata_i[CTRL_POLL];
      end
      if (we_i && addr_i == REG_CMD) cmd_q <= {1'b0, wdata_i[30:0]};
      if (done_i) begin
        err_q <= err_i;
        if (dir_wr_q) wdone_q <= 1'b1;
        else begin
          rdone_q <= 1'b1;
          data_q  <= xfer_rdata_i;
        end
      end
      if (start_o) begin
        dir_wr_q <= req_o.write;
        err_q    <= 1'b0;
        if (req_o.write) wdone_q <= 1'b0;
        else             rdone_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CTRL: begin
        rdata_o[CTRL_TYPE_LSB +: 4] = type_q;
        rdata_o[CTRL_CLKEN]         = clken_q;
        rdata_o[CTRL_WLOCK]         = wlock_q;
        rdata_o[CTRL_POLL]          = poll_q;
      end
      REG_CMD: rdata_o = cmd_q;
      REG_STAT: begin
        rdata_o[STAT_BUSY]  = busy_i;
        rdata_o[STAT_RDONE] = rdone_q;
        rdata_o[STAT_WDONE] = wdone_q;
        rdata_o[STAT_ERR]   = err_q;
        rdata_o[15:0]       = data_q;
      end
      default: rdata_o = '0;
    endcase
  end

  AST_RDONE_KEPT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && req_o.write && !done_i) |=> $stable(rdone_q)); // R7
  AST_WDONE_KEPT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && !req_o.write && !done_i) |=> $stable(wdone_q)); // R7
  AST_ERR_CLR_ON_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !err_q); // R8
endmodule

// File: rtl/smb_xfer.sv
module smb_xfer
  import smb_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        start_i,
  input  xfer_req_t   req_i,
  input  logic        sda_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [15:0] rdata_o,
  output logic        scl_oe_o,
  output logic        sda_oe_o
);
  localparam logic [3:0] ACK_BIT = 4'd8;

  xfer_state_e state_q;
  xfer_req_t   req_q;
  logic [1:0]  phase_q;
  logic [3:0]  bit_q;
  logic [7:0]  sr_q;
  logic        sel_q, nack_q, err_q, done_q;
  logic [15:0] rdata_q;
  logic        scl_q, sda_q, scl_d, sda_d;
  logic        is_tx, is_bit, more_rx;

  assign is_tx   = (state_q == ST_ADDR_W) || (state_q == ST_CMD) ||
                   (state_q == ST_WDATA)  || (state_q == ST_ADDR_R);
  assign is_bit  = is_tx || (state_q == ST_RDATA);
  assign more_rx = req_q.word && !sel_q;

  // pin drive per quarter phase; 1 = pull low
  always_comb begin
    scl_d = 1'b0;
    sda_d = 1'b0;
    unique case (state_q)
      ST_START, ST_RSTART: begin
        scl_d = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_d = phase_q[1];
      end
      ST_STOP: begin
        scl_d = (phase_q == 2'd0);
        sda_d = (phase_q <= 2'd1);
      end
      ST_ADDR_W, ST_CMD, ST_WDATA, ST_ADDR_R: begin
        scl_d = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_d = (bit_q != ACK_BIT) && !sr_q[7];
      end
      ST_RDATA: begin
        scl_d = (phase_q == 2'd0) || (phase_q == 2'd3);
        sda_d = (bit_q == ACK_BIT) && more_rx;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      phase_q <= '0;
      bit_q   <= '0;
      sr_q    <= '0;
      sel_q   <= 1'b0;
      nack_q  <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
      if (state_q == ST_IDLE) begin
        if (start_i) begin
          state_q <= ST_START;
          req_q   <= req_i;
          phase_q <= '0;
          bit_q   <= '0;
          err_q   <= 1'b0;
          rdata_q <= '0;
        end
      end else if (tick_i) begin
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd2 && is_tx && bit_q == ACK_BIT) nack_q <= sda_i;
        if (phase_q == 2'd2 && state_q == ST_RDATA && bit_q != ACK_BIT)
          sr_q <= {sr_q[6:0], sda_i};
        if (phase_q == 2'd3) begin
          if (is_bit && bit_q != ACK_BIT) begin
            bit_q <= bit_q + 4'd1;
            if (is_tx) sr_q <= {sr_q[6:0], 1'b0};
          end else begin
            bit_q <= '0;
            unique case (state_q)
              ST_START: begin
                state_q <= ST_ADDR_W;
                sr_q    <= {req_q.addr, 1'b0};
              end
              ST_ADDR_W: begin
                if (nack_q) begin err_q <= 1'b1; state_q <= ST_STOP; end
                else begin state_q <= ST_CMD; sr_q <= req_q.code; end
              end
              ST_CMD: begin
                if (nack_q) begin err_q <= 1'b1; state_q <= ST_STOP; end
                else if (req_q.write) begin
                  state_q <= ST_WDATA;
                  sr_q    <= req_q.wdata[7:0];
                  sel_q   <= 1'b0;
                end else state_q <= ST_RSTART;
              end
              ST_WDATA: begin
                if (nack_q) begin err_q <= 1'b1; state_q <= ST_STOP; end
                else if (req_q.word && !sel_q) begin
                  sel_q <= 1'b1;
                  sr_q  <= req_q.wdata[15:8];
                end else state_q <= ST_STOP;
              end
              ST_RSTART: begin
                state_q <= ST_ADDR_R;
                sr_q    <= {req_q.addr, 1'b1};
              end
              ST_ADDR_R: begin
                if (nack_q) begin err_q <= 1'b1; state_q <= ST_STOP; end
                else begin state_q <= ST_RDATA; sel_q <= 1'b0; end
              end
              ST_RDATA: begin
                if (sel_q) rdata_q[15:8] <= sr_q;
                else       rdata_q[7:0]  <= sr_q;
                if (more_rx) sel_q <= 1'b1;
                else         state_q <= ST_STOP;
              end
              ST_STOP: begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
              end
              default: state_q <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = done_q;
  assign err_o    = err_q;
  assign rdata_o  = rdata_q;
  assign scl_oe_o = scl_q;
  assign sda_oe_o = sda_q;

  AST_REQ_HELD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(req_q)); // R2
  AST_DONE_AFTER_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(state_q == ST_STOP)); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && $past(state_q == ST_IDLE)) |-> (!scl_q && !sda_q)); // R11
  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_bit && $past(is_bit) && !scl_q && $past(!scl_q)) |-> $stable(sda_q)); // R11
endmodule

// File: rtl/smb_cmd_master.sv
module smb_cmd_master
  import smb_pkg::*;
#(
  parameter int unsigned CLK_HZ = 100_000_000,
  parameter int unsigned SCL_HZ = 100_000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        sda_i,
  output logic        scl_oe_o,
  output logic        sda_oe_o
);
  localparam int unsigned QTR_CYC = CLK_HZ / (4 * SCL_HZ);

  logic        busy, done, err, start, tick;
  logic [15:0] xfer_rdata;
  xfer_req_t   req;

  smb_csr u_csr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_i         (reg_we_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .rdata_o      (reg_rdata_o),
    .busy_i       (busy),
    .done_i       (done),
    .err_i        (err),
    .xfer_rdata_i (xfer_rdata),
    .start_o      (start),
    .req_o        (req)
  );

  smb_tick_gen #(.QTR_CYC(QTR_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (busy),
    .tick_o (tick)
  );

  smb_xfer u_xfer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .start_i  (start),
    .req_i    (req),
    .sda_i    (sda_i),
    .busy_o   (busy),
    .done_o   (done),
    .err_o    (err),
    .rdata_o  (xfer_rdata),
    .scl_oe_o (scl_oe_o),
    .sda_oe_o (sda_oe_o)
  );
endmodule

// File: tb/sim_smb_cmd_master.sv
module sim_smb_cmd_master;
  localparam logic [6:0] SLV = 7'h18;
  localparam logic [3:0] TYPE = 4'h3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_oe, sda_oe;
  logic        slv_pull = 1'b0;
  logic        scl_w, sda_w;

  int vectors = 0;
  int fails = 0;
  bit fin = 1'b0;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slv_pull);

  always #5 clk = ~clk;

  smb_cmd_master #(.CLK_HZ(100_000_000), .SCL_HZ(2_500_000)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sda_i(sda_w),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe));

  // scoreboard queues
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         exp_ack_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor side: called by the target model per observed byte
  task automatic see_byte(logic [7:0] b);
    string t;
    logic [7:0] e;
    vectors++;
    if (exp_q.size() == 0) begin
      fails++;
      $display("FAIL R4: unexpected bus byte %h expected none", b);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (b !== e) begin
        fails++;
        $display("FAIL %s: bus byte %h expected %h", t, b, e);
      end
    end
  endtask

  task automatic see_ack(bit acked);
    bit e;
    vectors++;
    if (exp_ack_q.size() == 0) begin
      fails++;
      $display("FAIL R6: unexpected master ack %0d expected none", acked);
    end else begin
      e = exp_ack_q.pop_front();
      if (acked != e) begin
        fails++;
        $display("FAIL R6: master ack %0d expected %0d", acked, e);
      end
    end
  endtask

  // target model
  int         s_bit = -1;
  int         s_byte = 0;
  bit         s_act = 0, s_rd = 0, s_sel = 0, s_acked = 0;
  logic [7:0] s_sr = '0, s_cmd = '0, s_rb = '0;

  always @(negedge sda_w) if (scl_w === 1'b1) begin
    s_act = 1; s_bit = -1; s_byte = 0; slv_pull = 0;
  end
  always @(posedge sda_w) if (scl_w === 1'b1) begin
    s_act = 0; slv_pull = 0;
  end
  always @(posedge scl_w) if (s_act && s_bit >= 0) begin
    if (s_bit < 8) begin
      if (!(s_sel && s_rd && s_byte > 0)) s_sr = {s_sr[6:0], sda_w};
    end else if (s_sel && s_rd && s_byte > 0) s_acked = !sda_w;
  end
  always @(negedge scl_w) if (s_act) begin
    if (s_bit < 0) s_bit = 0;
    else if (s_bit < 7) begin
      s_bit++;
      if (s_sel && s_rd && s_byte > 0) slv_pull = !s_rb[7 - s_bit];
    end else if (s_bit == 7) begin
      s_bit = 8;
      if (s_sel && s_rd && s_byte > 0) slv_pull = 0;
      else begin
        see_byte(s_sr);
        if (s_byte == 0) begin
          s_sel = (s_sr[7:1] == SLV);
          s_rd = s_sr[0];
          slv_pull = s_sel;
        end else if (s_sel) begin
          if (s_byte == 1) s_cmd = s_sr;
          slv_pull = 1;
        end
      end
    end else begin
      s_bit = 0;
      slv_pull = 0;
      if (s_sel && s_rd && s_byte > 0) see_ack(s_acked);
      if (s_sel && s_rd && (s_byte == 0 || s_acked)) begin
        s_rb = s_cmd ^ (8'h3C + 8'(s_byte));
        slv_pull = !s_rb[7];
      end
      s_byte++;
    end
  end

  task automatic wr_reg(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  function automatic logic [31:0] cmdw(bit wr, bit wd, logic [2:0] a3,
                                      logic [7:0] c, logic [15:0] d);
    return {1'b1, 1'b0, wd, 1'b0, wr, a3, c, d};
  endfunction

  // driver: predict bus bytes then trigger
  task automatic run(string tag, bit wr, bit wd, logic [2:0] a3,
                     logic [7:0] c, logic [15:0] d);
    exp_q.push_back({TYPE, a3, 1'b0}); tag_q.push_back("R4");
    if (a3 == 3'd0) begin
      exp_q.push_back(c); tag_q.push_back("R4");
      if (wr) begin
        exp_q.push_back(d[7:0]); tag_q.push_back(tag);
        if (wd) begin exp_q.push_back(d[15:8]); tag_q.push_back(tag); end
      end else begin
        exp_q.push_back({TYPE, a3, 1'b1}); tag_q.push_back("R4");
        if (wd) exp_ack_q.push_back(1'b1);
        exp_ack_q.push_back(1'b0);
      end
    end
    wr_reg(2'd1, cmdw(wr, wd, a3, c, d));
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd_reg(2'd2, v);
      if (!v[31]) return;
    end
    chk("R2 busy never fell", 32'h1, 32'h0);
  endtask

  logic [31:0] v;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_reg(2'd0, v); chk("R1 ctrl", v, 32'h0);
    rd_reg(2'd1, v); chk("R1 cmd", v, 32'h0);
    rd_reg(2'd2, v); chk("R1 status", v, 32'h0);
    chk("R1 pins", {30'b0, scl_oe, sda_oe}, 32'h0);

    // R10 control readback
    wr_reg(2'd0, 32'h3800_0200);
    rd_reg(2'd0, v); chk("R10 ctrl", v, 32'h3800_0200);

    // R5 byte write, upper data ignored; R2 busy and retrigger ignored
    run("R5", 1, 0, 3'd0, 8'h12, 16'hAB34);
    rd_reg(2'd2, v); chk("R2 busy after trigger", v, 32'h8000_0000);
    wr_reg(2'd1, cmdw(0, 0, 3'd0, 8'h55, 16'h0));
    wait_idle();
    rd_reg(2'd2, v); chk("R2 retrigger ignored", v, 32'h2000_0000);

    // R5 word write, low byte first
    run("R5", 1, 1, 3'd0, 8'h40, 16'h5678);
    wait_idle();
    rd_reg(2'd2, v); chk("R5 word write done", v, 32'h2000_0000);

    // R6 byte read; R7 write flag kept
    run("R6", 0, 0, 3'd0, 8'h21, 16'h0);
    wait_idle();
    rd_reg(2'd2, v); chk("R6 byte read", v, 32'h6000_001D);

    // R6 word read
    run("R6", 0, 1, 3'd0, 8'h05, 16'h0);
    wait_idle();
    rd_reg(2'd2, v); chk("R6 word read", v, 32'h6000_3839);

    // R7 write start clears only write flag
    run("R7", 1, 0, 3'd0, 8'h07, 16'h00C3);
    rd_reg(2'd2, v); chk("R7 mid write", v, 32'hC000_3839);
    wait_idle();
    rd_reg(2'd2, v); chk("R7 after write", v, 32'h6000_3839);

    // R8 absent target
    run("R8", 0, 0, 3'd1, 8'h21, 16'h0);
    wait_idle();
    rd_reg(2'd2, v); chk("R8 nack error", v, 32'h7000_0000);
    run("R8", 0, 0, 3'd0, 8'h21, 16'h0);
    wait_idle();
    rd_reg(2'd2, v); chk("R8 error cleared", v, 32'h6000_001D);

    // R9 write lock
    wr_reg(2'd0, 32'h3C00_0200);
    wr_reg(2'd1, cmdw(1, 0, 3'd0, 8'h11, 16'h0022));
    rd_reg(2'd2, v); chk("R9 locked write ignored", v, 32'h6000_001D);
    repeat (50) @(negedge clk);
    chk("R9 bus idle", {30'b0, scl_oe, sda_oe}, 32'h0);
    run("R9", 0, 1, 3'd0, 8'h05, 16'h0);
    wait_idle();
    rd_reg(2'd2, v); chk("R9 read under lock", v, 32'h6000_3839);

    // R3 clock enable cleared
    wr_reg(2'd0, 32'h3000_0200);
    wr_reg(2'd1, cmdw(0, 0, 3'd0, 8'h21, 16'h0));
    rd_reg(2'd2, v); chk("R3 trigger ignored", v, 32'h6000_3839);
    repeat (50) @(negedge clk);
    rd_reg(2'd2, v); chk("R3 status kept", v, 32'h6000_3839);

    // R11 released at rest; all predicted traffic seen
    chk("R11 bus released", {30'b0, scl_oe, sda_oe}, 32'h0);
    chk("R4 all bytes seen", exp_q.size(), 32'h0);
    chk("R6 all acks seen", exp_ack_q.size(), 32'h0);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      fails++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule